// File: doc/BRIEF.md
# UART Clock Routing and Sampling-Mode Control

This block holds the 8-bit clock-select setting of one serial channel and turns it into the tick enables that drive that channel's receiver and transmitter. Each side takes its clock on its own. The receiver can take it from a dedicated clock pin, from the data-set-ready pin, from the baud divisor tick, or from whatever the transmitter uses. The transmitter can take it from the baud divisor tick or from an external clock on the ring-indicator pin. Two flags tell the shift logic whether each side samples at N-times oversampling or in 1x isochronous mode.

Every clock is handled as a single-cycle enable in the system clock domain. An external pin clock passes through a synchronizer, and its rising edges become one-cycle ticks. The block also picks what drives a shared modem-control output pin. That can be its normal function, the transmitter's 1x bit clock, the raw baud tick, or a fixed inactive level.

A hardware reset clears the setting. A channel soft reset leaves the setting alone and only restarts the bit-clock divider, so software can change clocks first and then reset the channel to clear any glitch.

Top module: `uart_clk_route`

## Requirements
- R1: A hardware reset (rst_ni low) clears the setting to 0x00. As a result, both 1x flags read 0 and the pin output follows the normal pin function.
- R2: A write stores cfg_wdata_i, and the new value is visible on cfg_rdata_o in the cycle after the write. Bit 2 is reserved and always reads 0.
- R3: soft_rst_i leaves the setting unchanged. It also restarts the transmitter bit-clock divider, so that the first bit tick after it comes on the OVERSAMPLE-th transmit tick.
- R4: Bits [1:0] choose the receive tick: 00 is the receive-clock pin edge, 01 is the data-set-ready pin edge, 10 is baud_tick_i (same cycle) and 11 is tx_tick_o. A rising pin edge gives a one-cycle tick in the cycle after the second rising clock edge that samples the pin high.
- R5: rx_1x_o equals bit 3 (1 = 1x isochronous, 0 = OVERSAMPLE-times).
- R6: Bit 6 chooses the transmit tick: 0 is baud_tick_i (same cycle), 1 is the ring-indicator pin edge, with the same latency as in R4.
- R7: tx_1x_o equals bit 7 (1 = 1x isochronous, 0 = OVERSAMPLE-times).
- R8: When bits [5:4] are 00, pin_o is the value pin_func_i had one cycle earlier.
- R9: When bits [5:4] are 01, pin_o is the transmitter bit tick delayed one cycle. The bit tick is every transmit tick when bit 7 is 1, and every OVERSAMPLE-th transmit tick when bit 7 is 0. In this mode pin_func_i has no effect.
- R10: When bits [5:4] are 10, pin_o is baud_tick_i delayed one cycle, and pin_func_i has no effect.
- R11: When bits [5:4] are 11, pin_o is held at PIN_IDLE (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| soft_rst_i | input | 1 | Channel soft reset; keeps the setting |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_wdata_i | input | 8 | Setting write data |
| cfg_rdata_o | output | 8 | Setting readback |
| baud_tick_i | input | 1 | Baud divisor tick enable |
| rx_clk_pin_i | input | 1 | Asynchronous receive-clock pin |
| dsr_pin_i | input | 1 | Asynchronous data-set-ready pin |
| ring_pin_i | input | 1 | Asynchronous ring-indicator pin |
| pin_func_i | input | 1 | Normal modem-control level for the shared pin |
| rx_tick_o | output | 1 | Receiver tick enable |
| tx_tick_o | output | 1 | Transmitter tick enable |
| rx_1x_o | output | 1 | Receiver 1x isochronous mode |
| tx_1x_o | output | 1 | Transmitter 1x isochronous mode |
| pin_o | output | 1 | Shared modem-control pin output |

## Verification
Results fall due at different cycles. The setting and the 1x flags change one cycle after a write. A tick taken from the baud divisor shows up in the same cycle. A tick taken from a pin shows up two clock edges after the pin is sampled high. pin_o always lags its selected source by one edge. A behavioural model in the bench keeps a short history of the pin samples and a bit-tick count, advances both at every rising edge, and compares every output at the falling edge that follows. Because of that, each result is checked in exactly the cycle it is due, under random pin, tick and soft-reset activity for a series of settings.

// File: rtl/uart_clk_pkg.sv
package uart_clk_pkg;
  typedef enum logic [1:0] {
    RX_SRC_PIN  = 2'b00,
    RX_SRC_DSR  = 2'b01,
    RX_SRC_BAUD = 2'b10,
    RX_SRC_TX   = 2'b11
  } rx_src_e;

  typedef enum logic [1:0] {
    PIN_NORMAL = 2'b00,
    PIN_TX_BIT = 2'b01,
    PIN_BAUD   = 2'b10,
    PIN_RSVD   = 2'b11
  } pin_sel_e;

  typedef struct packed {
    logic     tx_1x;   // [7]
    logic     tx_ext;  // [6]
    pin_sel_e pin_sel; // [5:4]
    logic     rx_1x;   // [3]
    logic     rsvd;    // [2]
    rx_src_e  rx_src;  // [1:0]
  } clk_cfg_t;

  localparam logic [7:0] CFG_WMASK = 8'hFB;
endpackage

// File: rtl/uart_clk_pin_edge.sv
module uart_clk_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  localparam int SR_W = SYNC_STAGES + 1;
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_W-2:0], pin_i};
  end

  assign rise_o = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];
endmodule

// File: rtl/uart_clk_bitdiv.sv
module uart_clk_bitdiv #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic one_x_i,
  output logic bit_tick_o
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (tick_i && !one_x_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign bit_tick_o = one_x_i ? tick_i : (tick_i & wrap);
endmodule

// File: rtl/uart_clk_pin_mux.sv
module uart_clk_pin_mux
  import uart_clk_pkg::*;
#(
  parameter logic PIN_IDLE = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_sel_e sel_i,
  input  logic     func_i,
  input  logic     bit_tick_i,
  input  logic     baud_tick_i,
  output logic     pin_o
);
  logic pin_d;

  always_comb begin
    unique case (sel_i)
      PIN_NORMAL: pin_d = func_i;
      PIN_TX_BIT: pin_d = bit_tick_i;
      PIN_BAUD:   pin_d = baud_tick_i;
      default:    pin_d = PIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else         pin_o <= pin_d;
  end
endmodule

// File: rtl/uart_clk_route.sv
module uart_clk_route
  import uart_clk_pkg::*;
#(
  parameter int   OVERSAMPLE  = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic       baud_tick_i,
  input  logic       rx_clk_pin_i,
  input  logic       dsr_pin_i,
  input  logic       ring_pin_i,
  input  logic       pin_func_i,
  output logic       rx_tick_o,
  output logic       tx_tick_o,
  output logic       rx_1x_o,
  output logic       tx_1x_o,
  output logic       pin_o
);
  localparam int NPINS = 3;
  localparam int P_RX = 0, P_DSR = 1, P_RING = 2;

  clk_cfg_t         cfg_q;
  logic [NPINS-1:0] pins, rises;
  logic             tx_bit_tick;

  // setting is only cleared by hardware reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= clk_cfg_t'(cfg_wdata_i & CFG_WMASK);
  end

  assign cfg_rdata_o = cfg_q;
  assign pins = {ring_pin_i, dsr_pin_i, rx_clk_pin_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    uart_clk_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .rise_o (rises[g])
    );
  end

  assign tx_tick_o = cfg_q.tx_ext ? rises[P_RING] : baud_tick_i;

  always_comb begin
    unique case (cfg_q.rx_src)
      RX_SRC_PIN:  rx_tick_o = rises[P_RX];
      RX_SRC_DSR:  rx_tick_o = rises[P_DSR];
      RX_SRC_BAUD: rx_tick_o = baud_tick_i;
      default:     rx_tick_o = tx_tick_o;
    endcase
  end

  assign rx_1x_o = cfg_q.rx_1x;
  assign tx_1x_o = cfg_q.tx_1x;

  uart_clk_bitdiv #(.DIV(OVERSAMPLE)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst_i),
    .tick_i     (tx_tick_o),
    .one_x_i    (cfg_q.tx_1x),
    .bit_tick_o (tx_bit_tick)
  );

  uart_clk_pin_mux #(.PIN_IDLE(PIN_IDLE)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (cfg_q.pin_sel),
    .func_i      (pin_func_i),
    .bit_tick_i  (tx_bit_tick),
    .baud_tick_i (baud_tick_i),
    .pin_o       (pin_o)
  );
endmodule

// File: rtl/uart_clk_route_chk.sv
module uart_clk_route_chk #(
  parameter logic PIN_IDLE = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       baud_tick_i,
  input logic       pin_func_i,
  input logic       rx_tick_o,
  input logic       tx_tick_o,
  input logic       rx_1x_o,
  input logic       tx_1x_o,
  input logic       pin_o
);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[2] == 1'b0);

  assert_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & 8'hFB));

  assert_soft_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !cfg_we_i) |=> $stable(cfg_rdata_o));

  assert_rx_baud_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[1:0] == 2'b10) |-> rx_tick_o == baud_tick_i);

  assert_rx_tx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[1:0] == 2'b11) |-> rx_tick_o == tx_tick_o);

  assert_rx_pin_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[1:0] == 2'b00 && $past(cfg_rdata_o[1:0]) == 2'b00 && rx_tick_o)
      |-> !$past(rx_tick_o));

  assert_rx_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_1x_o == cfg_rdata_o[3]);

  assert_tx_baud_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[6] |-> tx_tick_o == baud_tick_i);

  assert_tx_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_1x_o == cfg_rdata_o[7]);

  assert_pin_func_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_rdata_o[5:4]) == 2'b00) |-> pin_o == $past(pin_func_i));

  assert_pin_bit1x_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_rdata_o[5:4]) == 2'b01 && $past(cfg_rdata_o[7])) |-> pin_o == $past(tx_tick_o));

  assert_pin_baud_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_rdata_o[5:4]) == 2'b10) |-> pin_o == $past(baud_tick_i));

  assert_pin_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_rdata_o[5:4]) == 2'b11) |-> pin_o == PIN_IDLE);
endmodule

bind uart_clk_route uart_clk_route_chk #(.PIN_IDLE(PIN_IDLE)) u_chk (.*);

// File: tb/uart_clk_route_bench.sv
`timescale 1ns/1ps
module uart_clk_route_bench;
  localparam int N = 16;
  localparam logic IDLE = 1'b1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       baud = 1'b0, rxp = 1'b0, dsrp = 1'b0, ringp = 1'b0, func = 1'b0;
  logic [7:0] cfg_rd;
  logic       rx_tick, tx_tick, rx_1x, tx_1x, pin;

  int checks = 0, failures = 0, cycles = 0;
  bit running = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  uart_clk_route u_uart_clk_route (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rd), .baud_tick_i(baud),
    .rx_clk_pin_i(rxp), .dsr_pin_i(dsrp), .ring_pin_i(ringp), .pin_func_i(func),
    .rx_tick_o(rx_tick), .tx_tick_o(tx_tick), .rx_1x_o(rx_1x), .tx_1x_o(tx_1x),
    .pin_o(pin));

  // reference model
  logic [7:0] m_cfg;
  logic [2:0] h_rx, h_dsr, h_ring; // [0] newest sample
  int         m_cnt;
  logic       m_pin;

  function automatic logic rise(input logic [2:0] h);
    return h[1] & ~h[2];
  endfunction
  function automatic logic exp_tx();
    return m_cfg[6] ? rise(h_ring) : baud;
  endfunction
  function automatic logic exp_rx();
    case (m_cfg[1:0])
      2'b00: return rise(h_rx);
      2'b01: return rise(h_dsr);
      2'b10: return baud;
      default: return exp_tx();
    endcase
  endfunction
  function automatic logic exp_bit();
    return m_cfg[7] ? exp_tx() : (exp_tx() && m_cnt == N-1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 8'h00; h_rx = '0; h_dsr = '0; h_ring = '0; m_cnt = 0; m_pin = 1'b0;
    end else begin
      case (m_cfg[5:4])
        2'b00: m_pin = func;
        2'b01: m_pin = exp_bit();
        2'b10: m_pin = baud;
        default: m_pin = IDLE;
      endcase
      if (soft_rst) m_cnt = 0;
      else if (exp_tx() && !m_cfg[7]) m_cnt = (m_cnt == N-1) ? 0 : m_cnt + 1;
      if (cfg_we) m_cfg = cfg_wdata & 8'hFB;
      h_rx = {h_rx[1:0], rxp}; h_dsr = {h_dsr[1:0], dsrp}; h_ring = {h_ring[1:0], ringp};
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string pin_req();
    case (m_cfg[5:4])
      2'b00: return "R8 pin normal";
      2'b01: return "R9 pin tx bit clock";
      2'b10: return "R10 pin baud";
      default: return "R11 pin idle";
    endcase
  endfunction

  // compare every cycle, away from the active edge
  logic [1:0] prev_sel;
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2 readback", cfg_rd, m_cfg);
      chk("R4 rx tick", {7'd0, rx_tick}, {7'd0, exp_rx()});
      chk("R6 tx tick", {7'd0, tx_tick}, {7'd0, exp_tx()});
      chk("R5 rx 1x flag", {7'd0, rx_1x}, {7'd0, m_cfg[3]});
      chk("R7 tx 1x flag", {7'd0, tx_1x}, {7'd0, m_cfg[7]});
      chk(pin_req(), {7'd0, pin}, {7'd0, m_pin});
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cfg_we = 1'b0; soft_rst = 1'b0;
    baud = ($urandom_range(2) == 0);
    if ($urandom_range(3) == 0) rxp = ~rxp;
    if ($urandom_range(3) == 0) dsrp = ~dsrp;
    if ($urandom_range(3) == 0) ringp = ~ringp;
    func = $urandom_range(1);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  logic [7:0] cfgs [14] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h43, 8'h4B, 8'h10,
                            8'h90, 8'h11, 8'h20, 8'h30, 8'hFF, 8'hC6, 8'h51};

  initial begin
    #9 rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset setting", cfg_rd, 8'h00);
    chk("R1 reset flags", {6'd0, rx_1x, tx_1x}, 8'h00);
    for (int c = 0; c < 14; c++) begin
      write_cfg(cfgs[c]);
      @(negedge clk);
      chk("R2 write masks bit 2", cfg_rd, cfgs[c] & 8'hFB);
      for (int i = 0; i < 260; i++) begin
        step();
        if (i == 120) soft_rst = 1'b1;
      end
      // R3: soft reset keeps the setting
      @(posedge clk); #1; soft_rst = 1'b1;
      @(posedge clk); #1; soft_rst = 1'b0;
      @(negedge clk);
      chk("R3 setting kept over soft reset", cfg_rd, cfgs[c] & 8'hFB);
    end
    // R3: divider restart, 16x baud source, pin shows bit clock
    write_cfg(8'h10);
    baud = 1'b0;
    @(posedge clk); #1; soft_rst = 1'b1;
    @(posedge clk); #1; soft_rst = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1; baud = 1'b1;
      @(posedge clk); #1; baud = 1'b0;
      @(negedge clk);
      chk("R3 R9 bit tick after restart", {7'd0, pin}, {7'd0, (k == N-1)});
    end
    // R1: hardware reset clears
    rst_n = 1'b0; #3;
    chk("R1 hw reset clears", cfg_rd, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule